// File: doc/BRIEF.md
# DMA Channel Control and Status Unit

This block is the register-facing control plane for a bank of four DMA channel sequencers. Software reaches it through a single-cycle register port with a combinational read path. It holds, for each channel, the enable bit, the interrupt mask and a 7-bit request-source selector. It turns writes to the halt, channel-reset and software-kick registers into per-channel actions: pulses towards the sequencers or updates to the pending-request state.

The sequencers report their progress back as single-cycle pulses: transfer start, transfer finished, bus error and misaligned address. The unit keeps these as per-channel active, done, abort and misalignment flags. It merges them into a four-bit summary word, together with a wake flag, and drives one level-sensitive interrupt line. Each sequencer receives its enable, its pending request, a halt pulse, a reset pulse and its selector value.

A halted channel keeps its remaining transfer count. The halt pulse is separate from the reset pulse, so the sequencer does not rewind. When software sets the channel's enable bit again, the next request carries on from where the transfer stopped.

Top module: `dma_chan_ctl`

## Requirements
- R1: After reset every register reads 0, and ch_enable, ch_request, ch_pause, ch_reset, ch_srcsel and irq are all 0.
- R2: Word 0 is the enable register. Bit n belongs to channel n and can be read and written. ch_enable follows a write one cycle later. Bits above the channel count read 0.
- R3: Writing 1 to bit n of word 1 (halt) clears channel n's enable, pending request and active flag, and gives one one-cycle ch_pause[n] pulse. Bits written 0 change nothing. Word 1 reads 0.
- R4: A halt never pulses ch_reset, so the sequencer keeps its remaining count. After the enable bit is set again, a request to that channel becomes pending again.
- R5: Writing 1 to bit n of word 10 (channel reset) clears channel n's enable, pending request and active flag, and gives a one-cycle ch_reset[n] pulse. Word 10 reads 0.
- R6: Writing 1 to bit n of word 2 (software kick) sets channel n's pending request only if that channel is enabled. A kick to a disabled channel is dropped. Word 2 reads 0.
- R7: A peripheral request sets a channel's pending request only if the channel is enabled and its selector is nonzero.
- R8: Word 3 reads the pending requests and word 9 reads the active flags. Both are read-only. seq_start sets the active flag. seq_done or seq_abort clears both the pending request and the active flag.
- R9: Word 6 holds the abort flags, word 7 the done flags and word 8 the misalignment flags. The matching sequencer pulse sets a flag, and writing 1 clears it. If a set and a clear reach the same flag in the same cycle, the set wins.
- R10: Word 5 is the summary. Bit 0 is the OR of all abort flags, bit 1 the OR of all done flags and bit 2 the OR of all misalignment flags. Bit 3 is the wake flag, which wake_evt sets and writing 1 to bit 3 clears; set wins.
- R11: Word 11 holds the selectors. Channel n uses bits [8n+6:8n], and bit 8n+7 reads 0. ch_srcsel carries channel n in bits [7n+6:7n].
- R12: Word 4 is the interrupt mask. irq is high when, for any channel n whose mask bit is 1, the abort, done or misalignment flag of channel n is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| periph_req | input | 4 | Peripheral request pulse, one bit per channel |
| seq_start | input | 4 | Sequencer began a transfer |
| seq_done | input | 4 | Sequencer finished a transfer |
| seq_abort | input | 4 | Sequencer saw a bus error |
| seq_misalign | input | 4 | Sequencer found a misaligned address |
| wake_evt | input | 1 | Wake event pulse |
| ch_enable | output | 4 | Channel enable to the sequencers |
| ch_request | output | 4 | Pending request per channel |
| ch_pause | output | 4 | One-cycle halt pulse per channel |
| ch_reset | output | 4 | One-cycle reset pulse per channel |
| ch_srcsel | output | 28 | Request-source selector, 7 bits per channel |
| irq | output | 1 | Masked interrupt line |

## Verification
The key collision is a sequencer event arriving in the same cycle as a software write-1-to-clear of the flag that event sets. It applies to the done flags and to the summary wake bit. The bench provokes it by driving the register write and the event pulse on the same falling edge. It then reads the flag back and expects it still set. A plain clear in a later cycle must then bring the flag to zero.

A second same-cycle case is a halt write that coincides with a peripheral request to the channel being halted. Here the request must be lost, and both ch_request and ch_enable must read 0 afterwards.

// File: rtl/dma_cc_pkg.sv
package dma_cc_pkg;
  localparam int REG_AW     = 4;
  localparam int SEL_STRIDE = 8;

  typedef enum logic [REG_AW-1:0] {
    RA_ENABLE = 4'd0,
    RA_HALT   = 4'd1,
    RA_KICK   = 4'd2,
    RA_PEND   = 4'd3,
    RA_IRQEN  = 4'd4,
    RA_SUMM   = 4'd5,
    RA_ABORT  = 4'd6,
    RA_DONE   = 4'd7,
    RA_ALIGN  = 4'd8,
    RA_ACTIVE = 4'd9,
    RA_CHRST  = 4'd10,
    RA_SRCSEL = 4'd11
  } reg_sel_e;

  // summary word bit positions (decoded by software)
  localparam int SUM_ABORT = 0;
  localparam int SUM_DONE  = 1;
  localparam int SUM_ALIGN = 2;
  localparam int SUM_WAKE  = 3;
endpackage

// File: rtl/dma_cc_chan.sv
module dma_cc_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic en_we,
  input  logic en_wd,
  input  logic halt_we,
  input  logic rst_we,
  input  logic kick_we,
  input  logic preq,
  input  logic src_on,
  input  logic ev_start,
  input  logic ev_done,
  input  logic ev_abort,
  input  logic ev_misal,
  input  logic clr_abort,
  input  logic clr_done,
  input  logic clr_align,
  output logic en_q,
  output logic pend_q,
  output logic act_q,
  output logic abt_q,
  output logic dn_q,
  output logic al_q
);
  logic stop, hit, finish;
  logic en_d, pend_d, act_d, abt_d, dn_d, al_d;

  always_comb begin
    stop   = halt_we | rst_we;
    finish = ev_done | ev_abort;
    hit    = en_q & (kick_we | (preq & src_on));

    en_d = en_q;
    if (en_we) en_d = en_wd;
    if (stop)  en_d = 1'b0;

    pend_d = ((pend_q & ~finish) | hit) & ~stop;
    act_d  = ((act_q & ~finish) | ev_start) & ~stop;

    // event set takes priority over software clear
    abt_d = (abt_q & ~clr_abort) | ev_abort;
    dn_d  = (dn_q  & ~clr_done)  | ev_done;
    al_d  = (al_q  & ~clr_align) | ev_misal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
      act_q  <= 1'b0;
      abt_q  <= 1'b0;
      dn_q   <= 1'b0;
      al_q   <= 1'b0;
    end else begin
      en_q   <= en_d;
      pend_q <= pend_d;
      act_q  <= act_d;
      abt_q  <= abt_d;
      dn_q   <= dn_d;
      al_q   <= al_d;
    end
  end
endmodule

// File: rtl/dma_cc_regs.sv
module dma_cc_regs
  import dma_cc_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int SRC_W = 7,
  parameter int DW    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [REG_AW-1:0]    addr,
  input  logic [DW-1:0]        wdata,
  input  logic [NCH-1:0]       en_v,
  input  logic [NCH-1:0]       pend_v,
  input  logic [NCH-1:0]       act_v,
  input  logic [NCH-1:0]       abt_v,
  input  logic [NCH-1:0]       dn_v,
  input  logic [NCH-1:0]       al_v,
  input  logic                 wake_evt,
  output logic                 en_we,
  output logic [NCH-1:0]       en_wd,
  output logic [NCH-1:0]       halt_we,
  output logic [NCH-1:0]       rst_we,
  output logic [NCH-1:0]       kick_we,
  output logic [NCH-1:0]       clr_abt,
  output logic [NCH-1:0]       clr_dn,
  output logic [NCH-1:0]       clr_al,
  output logic [NCH-1:0]       irq_en_q,
  output logic [NCH*SRC_W-1:0] sel_flat,
  output logic [DW-1:0]        rdata
);
  localparam logic [NCH-1:0] NONE = '0;

  logic [SRC_W-1:0] sel_q [NCH];
  logic [SRC_W-1:0] sel_d [NCH];
  logic [NCH-1:0]   irq_en_d;
  logic             wake_q, wake_d;
  logic             sel_wr, irq_wr, wake_clr;
  logic             unused_wbits;

  assign unused_wbits = ^wdata;

  assign sel_wr   = we && (addr == RA_SRCSEL);
  assign irq_wr   = we && (addr == RA_IRQEN);
  assign wake_clr = we && (addr == RA_SUMM) && wdata[SUM_WAKE];

  assign en_we   = we && (addr == RA_ENABLE);
  assign en_wd   = wdata[NCH-1:0];
  assign halt_we = (we && addr == RA_HALT)  ? wdata[NCH-1:0] : NONE;
  assign rst_we  = (we && addr == RA_CHRST) ? wdata[NCH-1:0] : NONE;
  assign kick_we = (we && addr == RA_KICK)  ? wdata[NCH-1:0] : NONE;
  assign clr_abt = (we && addr == RA_ABORT) ? wdata[NCH-1:0] : NONE;
  assign clr_dn  = (we && addr == RA_DONE)  ? wdata[NCH-1:0] : NONE;
  assign clr_al  = (we && addr == RA_ALIGN) ? wdata[NCH-1:0] : NONE;

  always_comb begin
    irq_en_d = wdata[NCH-1:0];
    wake_d   = (wake_q & ~wake_clr) | wake_evt;
    for (int n = 0; n < NCH; n++) sel_d[n] = wdata[n*SEL_STRIDE +: SRC_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en_q <= '0;
      wake_q   <= 1'b0;
      for (int n = 0; n < NCH; n++) sel_q[n] <= '0;
    end else begin
      wake_q <= wake_d;
      if (irq_wr) irq_en_q <= irq_en_d;
      if (sel_wr) begin
        for (int n = 0; n < NCH; n++) sel_q[n] <= sel_d[n];
      end
    end
  end

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_sel
      assign sel_flat[g*SRC_W +: SRC_W] = sel_q[g];
    end
  endgenerate

  always_comb begin
    rdata = '0;
    case (addr)
      RA_ENABLE: rdata[NCH-1:0] = en_v;
      RA_PEND:   rdata[NCH-1:0] = pend_v;
      RA_IRQEN:  rdata[NCH-1:0] = irq_en_q;
      RA_SUMM: begin
        rdata[SUM_ABORT] = |abt_v;
        rdata[SUM_DONE]  = |dn_v;
        rdata[SUM_ALIGN] = |al_v;
        rdata[SUM_WAKE]  = wake_q;
      end
      RA_ABORT:  rdata[NCH-1:0] = abt_v;
      RA_DONE:   rdata[NCH-1:0] = dn_v;
      RA_ALIGN:  rdata[NCH-1:0] = al_v;
      RA_ACTIVE: rdata[NCH-1:0] = act_v;
      RA_SRCSEL: begin
        for (int n = 0; n < NCH; n++) rdata[n*SEL_STRIDE +: SRC_W] = sel_q[n];
      end
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
  import dma_cc_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int SRC_W = 7,
  parameter int DW    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [REG_AW-1:0]    reg_addr,
  input  logic [DW-1:0]        reg_wdata,
  output logic [DW-1:0]        reg_rdata,
  input  logic [NCH-1:0]       periph_req,
  input  logic [NCH-1:0]       seq_start,
  input  logic [NCH-1:0]       seq_done,
  input  logic [NCH-1:0]       seq_abort,
  input  logic [NCH-1:0]       seq_misalign,
  input  logic                 wake_evt,
  output logic [NCH-1:0]       ch_enable,
  output logic [NCH-1:0]       ch_request,
  output logic [NCH-1:0]       ch_pause,
  output logic [NCH-1:0]       ch_reset,
  output logic [NCH*SRC_W-1:0] ch_srcsel,
  output logic                 irq
);
  logic           en_we;
  logic [NCH-1:0] en_wd, halt_we, rst_we, kick_we;
  logic [NCH-1:0] clr_abt, clr_dn, clr_al;
  logic [NCH-1:0] irq_en, flag_abort, flag_done, flag_align, act_v;
  logic [NCH-1:0] pause_d, reset_d;

  dma_cc_regs #(.NCH(NCH), .SRC_W(SRC_W), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .en_v(ch_enable), .pend_v(ch_request), .act_v(act_v),
    .abt_v(flag_abort), .dn_v(flag_done), .al_v(flag_align),
    .wake_evt(wake_evt), .en_we(en_we), .en_wd(en_wd),
    .halt_we(halt_we), .rst_we(rst_we), .kick_we(kick_we),
    .clr_abt(clr_abt), .clr_dn(clr_dn), .clr_al(clr_al),
    .irq_en_q(irq_en), .sel_flat(ch_srcsel), .rdata(reg_rdata)
  );

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_ch
      dma_cc_chan u_chan (
        .clk(clk), .rst_n(rst_n),
        .en_we(en_we), .en_wd(en_wd[g]),
        .halt_we(halt_we[g]), .rst_we(rst_we[g]), .kick_we(kick_we[g]),
        .preq(periph_req[g]), .src_on(|ch_srcsel[g*SRC_W +: SRC_W]),
        .ev_start(seq_start[g]), .ev_done(seq_done[g]),
        .ev_abort(seq_abort[g]), .ev_misal(seq_misalign[g]),
        .clr_abort(clr_abt[g]), .clr_done(clr_dn[g]), .clr_align(clr_al[g]),
        .en_q(ch_enable[g]), .pend_q(ch_request[g]), .act_q(act_v[g]),
        .abt_q(flag_abort[g]), .dn_q(flag_done[g]), .al_q(flag_align[g])
      );
    end
  endgenerate

  always_comb begin
    pause_d = halt_we;
    reset_d = rst_we;
    irq     = |((flag_abort | flag_done | flag_align) & irq_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_pause <= '0;
      ch_reset <= '0;
    end else begin
      ch_pause <= pause_d;
      ch_reset <= reset_d;
    end
  end
endmodule

// File: rtl/dma_cc_chk.sv
module dma_cc_chk
  import dma_cc_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int SRC_W = 7,
  parameter int DW    = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_we,
  input logic [REG_AW-1:0]    reg_addr,
  input logic [DW-1:0]        reg_wdata,
  input logic [NCH-1:0]       periph_req,
  input logic [NCH-1:0]       seq_done,
  input logic [NCH-1:0]       ch_enable,
  input logic [NCH-1:0]       ch_request,
  input logic [NCH-1:0]       ch_reset,
  input logic [NCH*SRC_W-1:0] ch_srcsel,
  input logic [NCH-1:0]       irq_en,
  input logic [NCH-1:0]       flag_done,
  input logic                 irq
);
  a_r3_halt_drops_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == RA_HALT) |=> ((ch_enable & $past(reg_wdata[NCH-1:0])) == '0));

  a_r4_halt_no_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == RA_HALT) |=> (ch_reset == '0));

  a_r5_chrst_drops_request: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == RA_CHRST) |=> ((ch_request & $past(reg_wdata[NCH-1:0])) == '0));

  a_r6_kick_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == RA_KICK && periph_req == '0)
      |=> ((ch_request & ~$past(ch_enable) & ~$past(ch_request)) == '0));

  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_done != '0) |=> ((flag_done & $past(seq_done)) == $past(seq_done)));

  a_r11_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == RA_SRCSEL) |=> $stable(ch_srcsel));

  a_r12_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == '0) |-> !irq);
endmodule

bind dma_chan_ctl dma_cc_chk #(.NCH(NCH), .SRC_W(SRC_W), .DW(DW)) u_chk (.*);

// File: tb/tb_dma_chan_ctl.sv
`timescale 1ns/1ps
module tb_dma_chan_ctl;
  localparam int NCH = 4;
  localparam int SW  = 7;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             reg_we;
  logic [3:0]       reg_addr;
  logic [31:0]      reg_wdata;
  logic [31:0]      reg_rdata;
  logic [NCH-1:0]   periph_req, seq_start, seq_done, seq_abort, seq_misalign;
  logic             wake_evt;
  logic [NCH-1:0]   ch_enable, ch_request, ch_pause, ch_reset;
  logic [NCH*SW-1:0] ch_srcsel;
  logic             irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dma_chan_ctl dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .periph_req(periph_req),
    .seq_start(seq_start), .seq_done(seq_done), .seq_abort(seq_abort),
    .seq_misalign(seq_misalign), .wake_evt(wake_evt), .ch_enable(ch_enable),
    .ch_request(ch_request), .ch_pause(ch_pause), .ch_reset(ch_reset),
    .ch_srcsel(ch_srcsel), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
    reg_we = 1'b0; reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic pulse(input logic [3:0] st, input logic [3:0] dn, input logic [3:0] ab,
                       input logic [3:0] mis, input logic [3:0] pr, input logic wk);
    @(negedge clk);
    seq_start = st; seq_done = dn; seq_abort = ab; seq_misalign = mis;
    periph_req = pr; wake_evt = wk;
    @(negedge clk);
    seq_start = '0; seq_done = '0; seq_abort = '0; seq_misalign = '0;
    periph_req = '0; wake_evt = 1'b0;
  endtask

  task automatic clean();
    wr(4'd10, 32'hF);
    wr(4'd6, 32'hF); wr(4'd7, 32'hF); wr(4'd8, 32'hF);
    wr(4'd4, 32'h0); wr(4'd11, 32'h0); wr(4'd5, 32'h8);
  endtask

  task automatic t_reset();
    chk("R1 enable", 32'(ch_enable), 0);
    chk("R1 request", 32'(ch_request), 0);
    chk("R1 pause/reset", 32'({ch_pause, ch_reset}), 0);
    chk("R1 srcsel", 32'(ch_srcsel), 0);
    chk("R1 irq", 32'(irq), 0);
    for (int a = 0; a < 12; a++) rd_chk($sformatf("R1 word %0d", a), 4'(a), 0);
  endtask

  task automatic t_enable();
    wr(4'd0, 32'hFFFF_FFF5);
    chk("R2 ch_enable", 32'(ch_enable), 32'h5);
    rd_chk("R2 readback", 4'd0, 32'h5);
    wr(4'd0, 32'h0);
    chk("R2 cleared", 32'(ch_enable), 0);
  endtask

  task automatic t_kick();
    clean();
    wr(4'd0, 32'h5);
    wr(4'd2, 32'hF);
    chk("R6 kick only enabled", 32'(ch_request), 32'h5);
    rd_chk("R6 pending word", 4'd3, 32'h5);
    rd_chk("R6 kick reads 0", 4'd2, 0);
  endtask

  task automatic t_periph();
    clean();
    wr(4'd11, 32'h8A83_0080);
    rd_chk("R11 selector readback", 4'd11, 32'h0A03_0000);
    chk("R11 ch_srcsel", 32'(ch_srcsel), 32'({7'h0A, 7'h03, 7'h00, 7'h00}));
    wr(4'd0, 32'h7);
    pulse(4'h0, 4'h0, 4'h0, 4'h0, 4'hF, 1'b0);
    chk("R7 peripheral request gating", 32'(ch_request), 32'h4);
  endtask

  task automatic t_seq();
    clean();
    wr(4'd0, 32'hF); wr(4'd2, 32'hF);
    pulse(4'h3, 4'h0, 4'h0, 4'h0, 4'h0, 1'b0);
    rd_chk("R8 active set", 4'd9, 32'h3);
    pulse(4'h0, 4'h1, 4'h0, 4'h0, 4'h0, 1'b0);
    chk("R8 done clears pending", 32'(ch_request), 32'hE);
    rd_chk("R8 done clears active", 4'd9, 32'h2);
    pulse(4'h0, 4'h0, 4'h2, 4'h0, 4'h0, 1'b0);
    chk("R8 abort clears pending", 32'(ch_request), 32'hC);
    wr(4'd3, 32'h0); wr(4'd9, 32'hF);
    rd_chk("R8 pending read-only", 4'd3, 32'hC);
    rd_chk("R8 active read-only", 4'd9, 32'h0);
    rd_chk("R9 done flag", 4'd7, 32'h1);
    rd_chk("R9 abort flag", 4'd6, 32'h2);
  endtask

  task automatic t_pause();
    clean();
    wr(4'd0, 32'hF); wr(4'd2, 32'hF);
    pulse(4'h2, 4'h0, 4'h0, 4'h0, 4'h0, 1'b0);
    wr(4'd1, 32'h2);
    chk("R3 halt clears enable", 32'(ch_enable), 32'hD);
    chk("R3 halt clears pending", 32'(ch_request), 32'hD);
    chk("R3 halt pulse", 32'(ch_pause), 32'h2);
    chk("R4 halt no reset pulse", 32'(ch_reset), 0);
    rd_chk("R3 halt clears active", 4'd9, 0);
    @(negedge clk);
    chk("R3 halt pulse one cycle", 32'(ch_pause), 0);
    rd_chk("R3 halt reads 0", 4'd1, 0);
    wr(4'd0, 32'hF);
    chk("R4 re-enabled", 32'(ch_enable), 32'hF);
    wr(4'd2, 32'h2);
    chk("R4 resumed request", 32'(ch_request), 32'hF);
    chk("R4 no reset pulse on resume", 32'(ch_reset), 0);
  endtask

  task automatic t_chrst();
    wr(4'd10, 32'h4);
    chk("R5 reset clears enable", 32'(ch_enable), 32'hB);
    chk("R5 reset clears pending", 32'(ch_request), 32'hB);
    chk("R5 reset pulse", 32'(ch_reset), 32'h4);
    chk("R5 no halt pulse", 32'(ch_pause), 0);
    @(negedge clk);
    chk("R5 reset pulse one cycle", 32'(ch_reset), 0);
    rd_chk("R5 reset reads 0", 4'd10, 0);
  endtask

  task automatic t_flags();
    clean();
    pulse(4'h0, 4'h1, 4'h8, 4'h4, 4'h0, 1'b0);
    rd_chk("R9 done", 4'd7, 32'h1);
    rd_chk("R9 abort", 4'd6, 32'h8);
    rd_chk("R9 align", 4'd8, 32'h4);
    rd_chk("R10 summary", 4'd5, 32'h7);
    chk("R12 irq masked", 32'(irq), 0);
    wr(4'd4, 32'h1);
    chk("R12 irq on done ch0", 32'(irq), 1);
    rd_chk("R12 mask readback", 4'd4, 32'h1);
    wr(4'd7, 32'h1);
    chk("R12 irq after clear", 32'(irq), 0);
    rd_chk("R10 summary after clear", 4'd5, 32'h5);
    wr(4'd4, 32'h8);
    chk("R12 irq on abort ch3", 32'(irq), 1);
    wr(4'd6, 32'h8);
    chk("R12 irq after abort clear", 32'(irq), 0);
    wr(4'd8, 32'h4);
    rd_chk("R10 summary empty", 4'd5, 0);
  endtask

  task automatic t_collide();
    clean();
    pulse(4'h0, 4'h2, 4'h0, 4'h0, 4'h0, 1'b0);
    rd_chk("R9 done ch1", 4'd7, 32'h2);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 4'd7; reg_wdata = 32'h2; seq_done = 4'h2;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0; seq_done = '0;
    rd_chk("R9 set wins over clear", 4'd7, 32'h2);
    wr(4'd7, 32'h2);
    rd_chk("R9 plain clear", 4'd7, 0);
    pulse(4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 1'b1);
    rd_chk("R10 wake set", 4'd5, 32'h8);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 4'd5; reg_wdata = 32'h8; wake_evt = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0; wake_evt = 1'b0;
    rd_chk("R10 wake set wins", 4'd5, 32'h8);
    wr(4'd5, 32'h8);
    rd_chk("R10 wake cleared", 4'd5, 0);
    wr(4'd11, 32'h0000_0100);
    wr(4'd0, 32'h2);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 4'd1; reg_wdata = 32'h2; periph_req = 4'h2;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0; periph_req = '0;
    chk("R3 halt beats request", 32'(ch_request), 0);
    chk("R3 halt beats request enable", 32'(ch_enable), 0);
  endtask

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    periph_req = '0; seq_start = '0; seq_done = '0; seq_abort = '0;
    seq_misalign = '0; wake_evt = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable();
    t_kick();
    t_periph();
    t_seq();
    t_pause();
    t_chrst();
    t_flags();
    t_collide();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule